// File: doc/BRIEF.md
# Genlock Sync Timing Generator

This block is the raster timing core of a display controller that can lock onto an external video source. A horizontal dot counter and a vertical line counter, both clocked by the dot clock, run freely through programmable totals and produce active-low horizontal and vertical sync outputs by comparing against programmable sync start and width values. When genlock is enabled, the external sync inputs steer the counters: a falling edge on the external horizontal sync snaps the dot counter to the horizontal sync start and fires a one-cycle pulse that a clock generator uses to realign its dot phase.

The external vertical sync is handled more cautiously. It is sampled once per horizontal-sync-width interval, and only three low samples in a row arm a vertical load. The load waits for the next dot on which the horizontal counter reaches its sync start, so the line counter always moves in step with a line boundary. Interlaced scanning is supported through a field flag that flips once per frame and delays the vertical sync by half a line on odd fields.

Top module: `genlock_timer`

## Requirements
- R1: While rst_n is low, h_cnt and v_cnt are 0, field_odd and dot_phase_rst are 0, and hsync_n and vsync_n reflect those counter values (high for the default settings).
- R2: Without external presets, h_cnt steps by one per clock from 0 to h_total-1 and wraps to 0; v_cnt steps by one on each wrap of h_cnt and wraps from v_total-1 to 0.
- R3: hsync_n is 0 exactly when h_sync_start <= h_cnt < h_sync_start + h_sync_width, and 1 otherwise.
- R4: With interlace at 0, vsync_n is 0 exactly when v_sync_start <= v_cnt < v_sync_start + v_sync_width.
- R5: With genlock_en at 1, a high-to-low change of hsin is passed through a two-stage synchronizer, and h_cnt equals h_sync_start on the third clock edge after the first edge that sees hsin low; counting resumes from there.
- R6: dot_phase_rst is 1 for exactly one cycle, the same cycle in which R5 places h_cnt at h_sync_start, and is 0 at all other times.
- R7: With genlock_en at 1, the synchronized vsin is sampled once every h_sync_width clocks; after the third consecutive low sample the vertical load is armed, and v_cnt is set to v_sync_start in the first following cycle where h_cnt equals h_sync_start.
- R8: After a vertical load, no further load takes place while vsin stays low; a high sample is needed before three new low samples can arm the next one.
- R9: With genlock_en at 0, hsin and vsin have no effect: no counter preset and no dot_phase_rst pulse.
- R10: With interlace at 1, field_odd toggles whenever both counters wrap together; on odd fields vsync_n goes low at dot h_total/2 (rounded down) of line v_sync_start and returns high at that dot of line v_sync_start + v_sync_width. With interlace at 0, field_odd is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| genlock_en | input | 1 | 1 lets external sync inputs preset the counters |
| interlace | input | 1 | 1 selects interlaced scanning |
| h_total | input | HW | Dots per line |
| h_sync_start | input | HW | Dot where horizontal sync begins |
| h_sync_width | input | HW | Horizontal sync length in dots, also the vsin sampling interval |
| v_total | input | VW | Lines per field/frame |
| v_sync_start | input | VW | Line where vertical sync begins |
| v_sync_width | input | VW | Vertical sync length in lines |
| hsin | input | 1 | External horizontal sync, active low, asynchronous |
| vsin | input | 1 | External vertical sync, active low, asynchronous |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| dot_phase_rst | output | 1 | One-cycle dot phase reset pulse |
| field_odd | output | 1 | Current field is odd (interlaced mode) |
| h_cnt | output | HW | Current dot position |
| v_cnt | output | VW | Current line position |

## Verification
The bench builds the block with its default counter widths but programs a tiny raster of 20 dots by 10 lines, with a 4-dot horizontal sync at dot 12 and a 2-line vertical sync at line 6. One frame is then only 200 clocks, so every dot and line position, both fields of an interlaced pair and several frame wraps are compared against an arithmetic model in every cycle. The short 4-dot sampling interval keeps the three-sample qualification of the vertical input, its lower and upper delay bounds and the wait for a line's sync start within a couple of lines.

// File: rtl/gl_pkg.sv
package gl_pkg;
  // synchronizer depth for the external sync inputs
  localparam int SYNC_STAGES = 2;
  // consecutive low samples needed to arm a vertical load
  localparam int VLOW_RUN = 3;

  typedef struct packed {
    logic hfall;  // synchronized falling edge of the horizontal input
    logic vlow;   // synchronized vertical input is low
  } ext_evt_t;
endpackage

// File: rtl/gl_sync.sv
module gl_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] st_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [N-1:0] st_d;
    if (i == 0) begin : g_first
      assign st_d = d;
    end else begin : g_next
      assign st_d = st_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[i] <= '1;
      else        st_q[i] <= st_d;
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/gl_window.sv
module gl_window #(
  parameter int W = 10
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] start,
  input  logic [W-1:0] width,
  output logic         hit
);
  logic [W:0] lo, hi, c;
  always_comb begin
    c   = {1'b0, cnt};
    lo  = {1'b0, start};
    hi  = {1'b0, start} + {1'b0, width};
    hit = (c >= lo) && (c < hi);
  end
endmodule

// File: rtl/gl_vqual.sv
module gl_vqual #(
  parameter int W   = 10,
  parameter int RUN = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         vlow,
  input  logic [W-1:0] period,
  input  logic         hstart_next,
  output logic         vapply
);
  localparam int RW = $clog2(RUN + 1);

  logic [W-1:0]  samp_q, samp_d;
  logic [RW-1:0] run_q, run_d;
  logic          armed_q, armed_d;
  logic          tick, arm_set;

  always_comb begin
    tick    = (samp_q == period - 1'b1);
    samp_d  = tick ? '0 : samp_q + 1'b1;
    run_d   = run_q;
    if (tick) begin
      if (!vlow)                  run_d = '0;
      else if (run_q != RW'(RUN)) run_d = run_q + 1'b1;
    end
    arm_set = tick && vlow && (run_q == RW'(RUN - 1)) && en;
    vapply  = armed_q && hstart_next && en;
    if (!en)         armed_d = 1'b0;
    else if (vapply) armed_d = 1'b0;
    else if (arm_set) armed_d = 1'b1;
    else             armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q  <= '0;
      run_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      samp_q  <= samp_d;
      run_q   <= run_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/genlock_timer.sv
module genlock_timer
  import gl_pkg::*;
#(
  parameter int HW = 10,
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          genlock_en,
  input  logic          interlace,
  input  logic [HW-1:0] h_total,
  input  logic [HW-1:0] h_sync_start,
  input  logic [HW-1:0] h_sync_width,
  input  logic [VW-1:0] v_total,
  input  logic [VW-1:0] v_sync_start,
  input  logic [VW-1:0] v_sync_width,
  input  logic          hsin,
  input  logic          vsin,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          dot_phase_rst,
  output logic          field_odd,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt
);
  logic [1:0]    ext_s;
  ext_evt_t      evt;
  logic          hs_hist_q;
  logic [HW-1:0] h_cnt_q, h_next, h_half;
  logic [VW-1:0] v_cnt_q, v_next;
  logic          field_q, field_d, dot_q;
  logic          hpreset, h_wrap, v_wrap, hstart_next, vapply;
  logic          h_win, v_win, v_first, v_last, late_half, vs_act;

  gl_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({vsin, hsin}), .q(ext_s)
  );

  assign evt.hfall = hs_hist_q & ~ext_s[0];
  assign evt.vlow  = ~ext_s[1];

  // next-state of the counters
  always_comb begin
    hpreset     = genlock_en & evt.hfall;
    h_wrap      = (h_cnt_q == h_total - 1'b1);
    v_wrap      = (v_cnt_q == v_total - 1'b1);
    if (hpreset)     h_next = h_sync_start;
    else if (h_wrap) h_next = '0;
    else             h_next = h_cnt_q + 1'b1;
    hstart_next = (h_next == h_sync_start);
  end

  gl_vqual #(.W(HW), .RUN(VLOW_RUN)) u_vqual (
    .clk(clk), .rst_n(rst_n), .en(genlock_en), .vlow(evt.vlow),
    .period(h_sync_width), .hstart_next(hstart_next), .vapply(vapply)
  );

  always_comb begin
    if (vapply)      v_next = v_sync_start;
    else if (h_wrap) v_next = v_wrap ? '0 : v_cnt_q + 1'b1;
    else             v_next = v_cnt_q;
    if (!interlace)                    field_d = 1'b0;
    else if (h_wrap && v_wrap && !vapply) field_d = ~field_q;
    else                               field_d = field_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_hist_q <= 1'b1;
      h_cnt_q   <= '0;
      v_cnt_q   <= '0;
      field_q   <= 1'b0;
      dot_q     <= 1'b0;
    end else begin
      hs_hist_q <= ext_s[0];
      h_cnt_q   <= h_next;
      v_cnt_q   <= v_next;
      field_q   <= field_d;
      dot_q     <= hpreset;
    end
  end

  // sync decode
  gl_window #(.W(HW)) u_hwin (
    .cnt(h_cnt_q), .start(h_sync_start), .width(h_sync_width), .hit(h_win)
  );
  gl_window #(.W(VW)) u_vwin (
    .cnt(v_cnt_q), .start(v_sync_start), .width(v_sync_width), .hit(v_win)
  );

  always_comb begin
    h_half    = h_total >> 1;
    late_half = (h_cnt_q >= h_half);
    v_first   = (v_cnt_q == v_sync_start);
    v_last    = ({1'b0, v_cnt_q} == {1'b0, v_sync_start} + {1'b0, v_sync_width});
    if (field_q)
      vs_act = (v_win && !(v_first && !late_half)) || (v_last && !late_half);
    else
      vs_act = v_win;
  end

  assign hsync_n       = ~h_win;
  assign vsync_n       = ~vs_act;
  assign dot_phase_rst = dot_q;
  assign field_odd     = field_q;
  assign h_cnt         = h_cnt_q;
  assign v_cnt         = v_cnt_q;
endmodule

// File: rtl/gl_chk.sv
module gl_chk #(
  parameter int HW = 10,
  parameter int VW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          genlock_en,
  input logic          interlace,
  input logic [HW-1:0] h_total,
  input logic [HW-1:0] h_sync_start,
  input logic          dot_phase_rst,
  input logic          field_odd,
  input logic [HW-1:0] h_cnt,
  input logic [VW-1:0] v_cnt
);
  // R6
  dot_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dot_phase_rst |=> !dot_phase_rst);
  // R5
  dot_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dot_phase_rst |-> (h_cnt == h_sync_start));
  // R2
  hrange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_cnt < h_total);
  // R7
  vjump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((v_cnt == $past(v_cnt)) || (v_cnt == $past(v_cnt) + 1'b1) || (v_cnt == '0))
      |-> (h_cnt == h_sync_start));
  // R9
  genlock_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!genlock_en) |-> !dot_phase_rst);
  // R10
  field_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!interlace) |-> !field_odd);
endmodule

bind genlock_timer gl_chk #(.HW(HW), .VW(VW)) u_chk (.*);

// File: tb/sim_genlock_timer.sv
`timescale 1ns/1ps
module sim_genlock_timer;
  localparam int HT = 20, HS = 12, HWD = 4;
  localparam int VT = 10, VS = 6,  VWD = 2;

  logic clk = 1'b0;
  logic rst_n, genlock_en, interlace, hsin, vsin;
  logic hsync_n, vsync_n, dot_phase_rst, field_odd;
  logic [9:0] h_cnt, v_cnt;

  always #4 clk = ~clk;

  genlock_timer u0 (
    .clk(clk), .rst_n(rst_n), .genlock_en(genlock_en), .interlace(interlace),
    .h_total(10'(HT)), .h_sync_start(10'(HS)), .h_sync_width(10'(HWD)),
    .v_total(10'(VT)), .v_sync_start(10'(VS)), .v_sync_width(10'(VWD)),
    .hsin(hsin), .vsin(vsin), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .dot_phase_rst(dot_phase_rst), .field_odd(field_odd),
    .h_cnt(h_cnt), .v_cnt(v_cnt)
  );

  int cyc = 0, vecs = 0, errs = 0;
  int eh = 0, ev = 0, ef = 0;
  bit active = 0, vwin = 0;
  int hpre_cyc = -100, vlow_cyc = 0, vjumps = 0;

  always @(posedge clk) cyc++;

  task automatic chk(string req, string what, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_hs(int h);
    return (h >= HS && h < HS + HWD) ? 0 : 1;
  endfunction

  function automatic int exp_vs(int h, int v, int f);
    bit in_l = (v >= VS && v < VS + VWD);
    bit late = (h >= HT / 2);
    if (f == 0) return in_l ? 0 : 1;
    if ((v == VS && late) || (v > VS && v < VS + VWD) || (v == VS + VWD && !late)) return 0;
    return 1;
  endfunction

  // per-cycle model and comparison
  always @(negedge clk) begin
    int nh, nv, nf, d;
    bit pre;
    string hreq, vreq;
    if (active) begin
      nh = (eh == HT - 1) ? 0 : eh + 1;
      nv = ev; nf = ef;
      if (eh == HT - 1) begin
        nv = (ev == VT - 1) ? 0 : ev + 1;
        if (ev == VT - 1) nf = ef ^ 1;
      end
      if (!interlace) nf = 0;
      pre = (cyc == hpre_cyc) && genlock_en;
      if (pre) nh = HS;
      eh = nh; ev = nv; ef = nf;
      if (vwin && h_cnt == HS && v_cnt == VS && eh == HS && ev != VS) begin
        ev = VS; vjumps++;
        d = cyc - vlow_cyc;
        chk("R7", "vertical load delay in window", int'(d >= 2*HWD + 2 && d <= 3*HWD + HT + 4), 1);
      end
      hreq = (cyc == hpre_cyc) ? (genlock_en ? "R5" : "R9") : "R2";
      vreq = !genlock_en ? "R9" : (!vsin && !vwin) ? "R8" : "R2";
      chk(hreq, "h_cnt", int'(h_cnt), eh);
      chk(vreq, "v_cnt", int'(v_cnt), ev);
      chk("R3", "hsync_n", int'(hsync_n), exp_hs(eh));
      chk(interlace ? "R10" : "R4", "vsync_n", int'(vsync_n), exp_vs(eh, ev, ef));
      chk("R10", "field_odd", int'(field_odd), ef);
      chk("R6", "dot_phase_rst", int'(dot_phase_rst), int'(pre));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic hpulse();
    hsin = 1'b0; hpre_cyc = cyc + 3;
    step(5);
    hsin = 1'b1;
  endtask

  task automatic wait_frame_top();
    while (!(eh == 0 && ev == 0)) step(1);
  endtask

  task automatic vload_round();
    int j0;
    wait_frame_top();
    vsin = 1'b0; vlow_cyc = cyc; vwin = 1; j0 = vjumps;
    step(3*HWD + HT + 8);
    vwin = 0;
    chk("R7", "vertical loads after three low samples", vjumps - j0, 1);
    step(3*HT);  // still low: no re-arm (R8)
    chk("R8", "no second load while low", vjumps - j0, 1);
    vsin = 1'b1;
    step(20);
  endtask

  initial begin
    rst_n = 1'b0; genlock_en = 1'b0; interlace = 1'b0; hsin = 1'b1; vsin = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R1", "reset h_cnt", int'(h_cnt), 0);
      chk("R1", "reset v_cnt", int'(v_cnt), 0);
      chk("R1", "reset hsync_n", int'(hsync_n), 1);
      chk("R1", "reset vsync_n", int'(vsync_n), 1);
      chk("R1", "reset dot_phase_rst", int'(dot_phase_rst), 0);
      chk("R1", "reset field_odd", int'(field_odd), 0);
    end
    #1;
    rst_n = 1'b1; eh = 0; ev = 0; ef = 0; active = 1;
    step(230);                 // free run over a full frame (R2, R3, R4)
    step(3); hpulse(); step(40);   // genlock off: ignored (R9)
    genlock_en = 1'b1;
    step(7); hpulse(); step(33);   // preset (R5, R6)
    step(11); hpulse(); step(50);
    vload_round();                 // R7, R8
    vload_round();
    genlock_en = 1'b0;
    wait_frame_top();
    vsin = 1'b0; step(80); vsin = 1'b1; step(10);  // R9
    interlace = 1'b1;
    step(450);                     // R10
    interlace = 1'b0;
    step(30);
    active = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule